// File: doc/BRIEF.md
# Slow Clock Error Detector

This block watches an asynchronous peripheral clock from the system bus clock domain and reports when the peripheral clock has fallen below one sixteenth of the bus clock frequency. A single flop in the peripheral domain inverts on every rising peripheral edge. The resulting toggle crosses into the bus domain through a two-flop synchronizer, and every change of the synchronized bit is counted as one peripheral edge.

Edges are counted over a fixed window of bus cycles, 64 by default. If a window closes with fewer than the threshold number of edges (4 by default, which is 64/16), the live error status is set. If the window closes with enough edges, the live status is cleared. The live status changes only when a window closes. A separate sticky flag latches every failed window and stays set until software writes a zero to it. A write of one has no effect on the flag, and a failed window that closes in the same cycle as a clear keeps the flag set.

Top module: `slow_clk_monitor`

## Requirements
- R1: A window of 64 bus cycles that sees fewer than 4 synchronized peripheral edges is a failed window. With the peripheral clock at 1/8 of the bus rate no window fails. With it at 1/32 of the bus rate, or stopped, every window fails.
- R2: `errLive` is 1 after a failed window and returns to 0 after the first window that closes with at least 4 edges.
- R3: `errSticky` is set by every failed window and stays at 1 after the clock recovers, as long as no zero is written to it.
- R4: A cycle with `flagWrEn`=1 and `flagWrData`=0 clears `errSticky` at the next bus edge. A cycle with `flagWrEn`=1 and `flagWrData`=1 leaves `errSticky` unchanged.
- R5: If a failed window closes in the same cycle as a zero write, `errSticky` ends up at 1.
- R6: An active-low `rstN` sets `errLive` and `errSticky` to 0 and restarts both the window count and the edge count.
- R7: `errLive` changes only when a window closes. After reset is released, the first possible change is at the 64th bus edge, and later changes fall on every 64th edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | System bus clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| perClk | input | 1 | Peripheral clock under supervision |
| flagWrEn | input | 1 | Software write strobe for the sticky flag |
| flagWrData | input | 1 | Value written to the sticky flag; only 0 has an effect |
| errLive | output | 1 | Live clock-error status, updated at each window close |
| errSticky | output | 1 | Sticky clock-error flag |

## Verification
A change of the peripheral clock rate takes between one and two windows to appear on `errLive`, because the window that is open when the rate changes mixes the old and new rates. The bench therefore waits three full windows after every rate change before it samples the outputs. For the timing checks, the bench counts bus edges from reset release. It samples `errLive` after edge 63 and after edge 64, and it drives a zero write so that it is sampled at the exact edge where a failed window closes. A write is checked one bus edge after it is driven. All outputs are sampled on the falling edge of the bus clock.

// File: rtl/scd_pkg.sv
package scd_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic windowEnd;  // last bus cycle of the measurement window
    logic clearReq;   // software wrote zero to the sticky flag
  } scd_strobe_t;
endpackage

// File: rtl/scd_toggle_src.sv
module scd_toggle_src (
  input  logic perClk,
  input  logic rstN,
  output logic perToggle
);
  always_ff @(posedge perClk or negedge rstN) begin
    if (!rstN) perToggle <= 1'b0;
    else       perToggle <= ~perToggle;
  end
endmodule

// File: rtl/scd_control.sv
module scd_control
  import scd_pkg::*;
#(
  parameter int WINDOW_CYCLES = 64
) (
  input  logic        busClk,
  input  logic        rstN,
  input  logic        flagWrEn,
  input  logic        flagWrData,
  output scd_strobe_t ctlStrobes
);
  localparam int WIN_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_CYCLES - 1);

  logic [WIN_W-1:0] winCnt;

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN)                winCnt <= '0;
    else if (winCnt == WIN_LAST) winCnt <= '0;
    else                      winCnt <= winCnt + 1'b1;
  end

  always_comb begin
    ctlStrobes.windowEnd = (winCnt == WIN_LAST);
    ctlStrobes.clearReq  = flagWrEn & ~flagWrData;
  end
endmodule

// File: rtl/scd_datapath.sv
module scd_datapath
  import scd_pkg::*;
#(
  parameter int MIN_TOGGLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        busClk,
  input  logic        rstN,
  input  logic        perToggle,
  input  scd_strobe_t ctlStrobes,
  output logic        errLive,
  output logic        errSticky
);
  localparam int CNT_W = $clog2(MIN_TOGGLES + 1);
  localparam int PIPE  = SYNC_STAGES + 1;
  localparam logic [CNT_W:0] MIN_VAL = (CNT_W+1)'(MIN_TOGGLES);

  logic [PIPE-1:0]  syncPipe;
  logic             edgeSeen;
  logic [CNT_W-1:0] togCnt;
  logic [CNT_W:0]   togSum;
  logic             windowFail;
  logic             setSticky;

  // synchronizer plus one history flop for change detection
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[PIPE-2:0], perToggle};
  end

  assign edgeSeen   = syncPipe[PIPE-1] ^ syncPipe[PIPE-2];
  assign togSum     = {1'b0, togCnt} + {{CNT_W{1'b0}}, edgeSeen};
  assign windowFail = togSum < MIN_VAL;
  assign setSticky  = ctlStrobes.windowEnd & windowFail;

  // saturating edge counter, restarted at each window close
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN)                     togCnt <= '0;
    else if (ctlStrobes.windowEnd) togCnt <= '0;
    else if (togSum >= MIN_VAL)    togCnt <= CNT_W'(MIN_TOGGLES);
    else                           togCnt <= togSum[CNT_W-1:0];
  end

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN)                     errLive <= 1'b0;
    else if (ctlStrobes.windowEnd) errLive <= windowFail;
  end

  // set has priority over a software clear
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN)                    errSticky <= 1'b0;
    else if (setSticky)           errSticky <= 1'b1;
    else if (ctlStrobes.clearReq) errSticky <= 1'b0;
  end
endmodule

// File: rtl/slow_clk_monitor.sv
module slow_clk_monitor
  import scd_pkg::*;
#(
  parameter int WINDOW_CYCLES = 64,
  parameter int MIN_TOGGLES   = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic busClk,
  input  logic rstN,
  input  logic perClk,
  input  logic flagWrEn,
  input  logic flagWrData,
  output logic errLive,
  output logic errSticky
);
  logic        perToggle;
  scd_strobe_t ctlStrobes;

  scd_toggle_src src_i (
    .perClk    (perClk),
    .rstN      (rstN),
    .perToggle (perToggle)
  );

  scd_control #(.WINDOW_CYCLES(WINDOW_CYCLES)) ctl_i (
    .busClk     (busClk),
    .rstN       (rstN),
    .flagWrEn   (flagWrEn),
    .flagWrData (flagWrData),
    .ctlStrobes (ctlStrobes)
  );

  scd_datapath #(.MIN_TOGGLES(MIN_TOGGLES), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .busClk     (busClk),
    .rstN       (rstN),
    .perToggle  (perToggle),
    .ctlStrobes (ctlStrobes),
    .errLive    (errLive),
    .errSticky  (errSticky)
  );
endmodule

// File: rtl/scd_checker.sv
module scd_checker (
  input logic busClk,
  input logic rstN,
  input logic flagWrEn,
  input logic flagWrData,
  input logic winEnd,
  input logic errLive,
  input logic errSticky
);
  AST_LIVE_ONLY_AT_CLOSE: assert property (@(posedge busClk) disable iff (!rstN)
    !winEnd |=> $stable(errLive)); // R7

  AST_RISE_SETS_STICKY: assert property (@(posedge busClk) disable iff (!rstN)
    $rose(errLive) |-> errSticky); // R3

  AST_STICKY_HOLDS: assert property (@(posedge busClk) disable iff (!rstN)
    (errSticky && (!flagWrEn || flagWrData)) |=> errSticky); // R3

  AST_ZERO_WRITE_CLEARS: assert property (@(posedge busClk) disable iff (!rstN)
    (flagWrEn && !flagWrData && !winEnd) |=> !errSticky); // R4

  AST_FAIL_BEATS_CLEAR: assert property (@(posedge busClk) disable iff (!rstN)
    (winEnd && flagWrEn && !flagWrData) |=> (errSticky == errLive) || errSticky); // R5

  AST_LIVE_LE_STICKY_AT_CLOSE: assert property (@(posedge busClk) disable iff (!rstN)
    (winEnd && !flagWrEn) |=> (!errLive || errSticky)); // R2
endmodule

bind slow_clk_monitor scd_checker chk_i (
  .busClk     (busClk),
  .rstN       (rstN),
  .flagWrEn   (flagWrEn),
  .flagWrData (flagWrData),
  .winEnd     (ctlStrobes.windowEnd),
  .errLive    (errLive),
  .errSticky  (errSticky)
);

// File: tb/slow_clk_monitor_tb.sv
`timescale 1ns/1ps
module slow_clk_monitor_tb_top;
  localparam int WIN = 64;

  logic busClk = 1'b0;
  logic perClk = 1'b0;
  logic rstN = 1'b0;
  logic flagWrEn = 1'b0;
  logic flagWrData = 1'b0;
  logic errLive, errSticky;

  logic perRun = 1'b0;
  realtime perHalf = 5.0;
  int nChecks = 0;
  int nFails = 0;

  always #2.5 busClk = ~busClk; // 200 MHz

  always begin
    if (perRun) #(perHalf) perClk = ~perClk;
    else        #1;
  end

  slow_clk_monitor dut_i (
    .busClk(busClk), .rstN(rstN), .perClk(perClk),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .errLive(errLive), .errSticky(errSticky)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge busClk);
  endtask

  task automatic setPer(input bit run, input realtime half);
    perHalf = half;
    perRun  = run;
  endtask

  // R6: reset state, with the peripheral clock stopped so the first window fails
  task automatic test_reset_and_first_close();
    setPer(0, 5.0);
    @(negedge busClk);
    rstN = 1'b0;
    waitNeg(2);
    chk("R6", "errLive in reset", errLive, 1'b0);
    chk("R6", "errSticky in reset", errSticky, 1'b0);
    rstN = 1'b1;
    waitNeg(63);
    chk("R7", "errLive before first close", errLive, 1'b0);
    waitNeg(1);
    chk("R7", "errLive at edge 64", errLive, 1'b1);
    chk("R1", "stopped clock fails", errSticky, 1'b1);
  endtask

  task automatic test_fast_clock();
    setPer(1, 20.0); // 1/8 of bus rate
    waitNeg(3*WIN);
    chk("R1", "1/8 rate live", errLive, 1'b0);
    chk("R3", "sticky kept after recovery", errSticky, 1'b1);
    waitNeg(2*WIN);
    chk("R2", "live stays clear", errLive, 1'b0);
  endtask

  task automatic test_writes();
    flagWrEn = 1'b1; flagWrData = 1'b1;
    @(negedge busClk);
    flagWrEn = 1'b0;
    chk("R4", "write one ignored", errSticky, 1'b1);
    waitNeg(3);
    chk("R4", "write one ignored later", errSticky, 1'b1);
    flagWrEn = 1'b1; flagWrData = 1'b0;
    @(negedge busClk);
    flagWrEn = 1'b0;
    chk("R4", "write zero clears", errSticky, 1'b0);
    waitNeg(2*WIN);
    chk("R3", "no spurious set", errSticky, 1'b0);
  endtask

  task automatic test_slow_clock();
    setPer(1, 80.0); // 1/32 of bus rate
    waitNeg(3*WIN);
    chk("R1", "1/32 rate live", errLive, 1'b1);
    chk("R2", "1/32 rate sticky", errSticky, 1'b1);
  endtask

  task automatic test_set_beats_clear();
    int guard;
    setPer(0, 5.0);
    waitNeg(2*WIN);
    flagWrEn = 1'b1; flagWrData = 1'b0;
    @(negedge busClk);
    flagWrEn = 1'b0;
    chk("R4", "clear while failing", errSticky, 1'b0);
    guard = 0;
    while (errSticky !== 1'b1 && guard < 2*WIN) begin
      @(negedge busClk);
      guard++;
    end
    chk("R3", "fail window sets again", errSticky, 1'b1);
    waitNeg(WIN-1);
    flagWrEn = 1'b1; flagWrData = 1'b0; // sampled at the next window close
    @(negedge busClk);
    flagWrEn = 1'b0;
    chk("R5", "set wins over clear", errSticky, 1'b1);
    chk("R2", "live still set", errLive, 1'b1);
  endtask

  task automatic test_recover_then_reset();
    setPer(1, 20.0);
    waitNeg(3*WIN);
    chk("R2", "live clears after recovery", errLive, 1'b0);
    chk("R3", "sticky survives recovery", errSticky, 1'b1);
    rstN = 1'b0;
    waitNeg(1);
    chk("R6", "reset clears sticky", errSticky, 1'b0);
    rstN = 1'b1;
    waitNeg(3*WIN);
    chk("R6", "clean restart live", errLive, 1'b0);
    chk("R6", "clean restart sticky", errSticky, 1'b0);
  endtask

  initial begin
    test_reset_and_first_close();
    test_fast_clock();
    test_writes();
    test_slow_clock();
    test_set_beats_clear();
    test_recover_then_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge busClk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule